// File: doc/BRIEF.md
# Paged Host Register Bus Interface

This block connects an 8-bit, non-multiplexed parallel host bus to the register file of a line framer. A static mode pin chooses between two strobe conventions on the same two control pins. One convention uses a separate read strobe and write strobe. The other uses one data strobe plus a read/write direction line. Every bus transfer is synchronised into the internal clock domain before it touches any register. Writes take effect when the strobe is released. Read data is placed on the bus only while a qualified read is in progress.

The host sees a window of 32 addresses. The top address of the window holds the page selector, and it is visible on every page. All other addresses reach the register at that offset on the currently selected page. Page 0 also holds an interrupt pending register and an interrupt enable register. A register file of plain read/write storage fills the remaining locations and serves as the test target. Interrupt events are collected into the pending register. They are reported on an active-low request output that works whether or not the chip is selected.

Top module: `parbus_regif`

## Requirements
- R1: After an active-low reset, the data enable is low and irqN is high. The page selector reads 0, and every storage register reads 0.
- R2: With intelMode high, holding rdDsN low reads a register and holding wrRwN low writes one. A value written in this mode reads back unchanged.
- R3: With intelMode low, rdDsN is a data strobe. While it is low, wrRwN high requests a read and wrRwN low requests a write. Values written in this mode read back unchanged, and values written in the other mode are visible too.
- R4: While csN is high, dataOe stays low and strobe activity changes no register.
- R5: Address 0x1F is the page selector. Only its bit 0 is used, and it is readable on any page. Address 0x05 on page 0 and address 0x05 on page 1 hold independent values.
- R6: A write stores the data present in the last synchronised cycle before the strobe is released. Earlier values driven during the same strobe are discarded.
- R7: A one-cycle pulse on bit n of intSrc sets pending bit n. If enable bit n is set, irqN goes low within two cycles, even with csN high.
- R8: Page 0 address 0x00 reads the pending bits. When that read ends, the bits it returned are cleared, and irqN returns high if no other enabled bit is pending.
- R9: Page 0 address 0x01 is the interrupt enable register, and its reset value is 0. A source whose enable bit is clear still sets its pending bit but does not drive irqN. Writes to address 0x00 are ignored.
- R10: dataOe rises only during a read with csN low. It falls as soon as csN goes high, and it falls once the read strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous reset |
| intelMode | input | 1 | Strobe convention: 1 = separate read/write strobes, 0 = data strobe with direction line |
| csN | input | 1 | Active-low chip select |
| rdDsN | input | 1 | Read strobe (mode 1) or data strobe (mode 0), active low |
| wrRwN | input | 1 | Write strobe, active low (mode 1), or direction, 1 = read (mode 0) |
| addr | input | 5 | Register address, bit 0 least significant |
| dataIn | input | 8 | Write data from the host bus |
| dataOut | output | 8 | Read data toward the host bus |
| dataOe | output | 1 | High when dataOut must drive the bus pins; low means high impedance |
| intSrc | input | 8 | Internal interrupt event pulses, one per bit |
| irqN | output | 1 | Active-low interrupt request; the value of an open-drain line with a pull-up |

## Verification
A corrupted page selector shows up on the next read as data from the wrong bank, or as a wrong page readback at 0x1F. A strobe edge detector that fires twice or never leaves a stale value or a missing write. Each such fault is visible at dataOut on the first read that follows, roughly ten cycles after the bad write. Pending state that is lost or cleared too early reaches irqN within two cycles of the source pulse or of the end of the status read. The bench samples irqN at exactly those points.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int HB_ADDR_W = 5;
  localparam int HB_DATA_W = 8;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic                 wrCommit;  // one-cycle pulse: store wdata at addr
    logic                 rdLatch;   // one-cycle pulse: capture read data
    logic                 rdDone;    // one-cycle pulse: read strobe released
    logic [HB_ADDR_W-1:0] addr;
    logic [HB_DATA_W-1:0] wdata;
  } hbStrobe_t;
endpackage

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 intelMode,
  input  logic                 csN,
  input  logic                 rdDsN,
  input  logic                 wrRwN,
  input  logic [HB_ADDR_W-1:0] addr,
  input  logic [HB_DATA_W-1:0] dataIn,
  output hbStrobe_t            strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic rdRaw, wrRaw;
  logic [SYNC_STAGES-1:0] rdSync, wrSync;
  logic rdPrev, wrPrev;
  logic [HB_ADDR_W-1:0] addrQ;
  logic [HB_DATA_W-1:0] dataQ;

  // Decode the shared pins according to the selected convention
  always_comb begin
    if (intelMode) begin
      rdRaw = !csN && !rdDsN;
      wrRaw = !csN && !wrRwN;
    end else begin
      rdRaw = !csN && !rdDsN && wrRwN;
      wrRaw = !csN && !rdDsN && !wrRwN;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rdSync <= '0;
          wrSync <= '0;
        end else begin
          rdSync <= rdRaw;
          wrSync <= wrRaw;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rdSync <= '0;
          wrSync <= '0;
        end else begin
          rdSync <= {rdSync[SYNC_STAGES-2:0], rdRaw};
          wrSync <= {wrSync[SYNC_STAGES-2:0], wrRaw};
        end
      end
    end
  endgenerate

  // Address and data are captured while the first stage sees the strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev <= 1'b0;
      wrPrev <= 1'b0;
      addrQ  <= '0;
      dataQ  <= '0;
    end else begin
      rdPrev <= rdSync[LAST];
      wrPrev <= wrSync[LAST];
      if (rdSync[0] || wrSync[0]) addrQ <= addr;
      if (wrSync[0])              dataQ <= dataIn;
    end
  end

  always_comb begin
    strobe.rdLatch  = rdSync[LAST] && !rdPrev;
    strobe.rdDone   = !rdSync[LAST] && rdPrev;
    strobe.wrCommit = !wrSync[LAST] && wrPrev;
    strobe.addr     = addrQ;
    strobe.wdata    = dataQ;
  end
endmodule

// File: rtl/hbus_datapath.sv
module hbus_datapath
  import hbus_pkg::*;
#(
  parameter int NUM_PAGES = 2,
  parameter int INT_W     = 8,
  parameter int PAGE_ADDR = 31,
  parameter int STAT_ADDR = 0,
  parameter int IEN_ADDR  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hbStrobe_t            strobe,
  input  logic [INT_W-1:0]     intSrc,
  output logic [HB_DATA_W-1:0] rdData,
  output logic                 rdActive,
  output logic [INT_W-1:0]     pendQ,
  output logic [INT_W-1:0]     enQ
);
  localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int REGS   = 2 ** HB_ADDR_W - 1;

  logic [PAGE_W-1:0]    pageQ;
  logic [HB_DATA_W-1:0] bankRd [NUM_PAGES];
  logic [HB_DATA_W-1:0] rdMux;
  logic                 statRead;
  logic                 onPage0, hitPage, hitStat, hitIen;

  always_comb begin
    onPage0 = (pageQ == '0);
    hitPage = (strobe.addr == HB_ADDR_W'(PAGE_ADDR));
    hitStat = onPage0 && (strobe.addr == HB_ADDR_W'(STAT_ADDR));
    hitIen  = onPage0 && (strobe.addr == HB_ADDR_W'(IEN_ADDR));
  end

  // One storage bank per page
  genvar p;
  generate
    for (p = 0; p < NUM_PAGES; p++) begin : g_bank
      logic [HB_DATA_W-1:0] bankMem [REGS];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < REGS; i++) bankMem[i] <= '0;
        end else if (strobe.wrCommit && !hitPage &&
                     (pageQ == PAGE_W'(p))) begin
          bankMem[strobe.addr] <= strobe.wdata;
        end
      end
      assign bankRd[p] = hitPage ? '0 : bankMem[strobe.addr];
    end
  endgenerate

  // Page selector and interrupt enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ <= '0;
      enQ   <= '0;
    end else if (strobe.wrCommit) begin
      if (hitPage) pageQ <= strobe.wdata[PAGE_W-1:0];
      if (hitIen)  enQ   <= strobe.wdata[INT_W-1:0];
    end
  end

  // Pending bits: set by events, cleared by the end of a status read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
    end else if (strobe.rdDone && statRead) begin
      pendQ <= (pendQ & ~rdData[INT_W-1:0]) | intSrc;
    end else begin
      pendQ <= pendQ | intSrc;
    end
  end

  always_comb begin
    if (hitPage)      rdMux = HB_DATA_W'(pageQ);
    else if (hitStat) rdMux = HB_DATA_W'(pendQ);
    else if (hitIen)  rdMux = HB_DATA_W'(enQ);
    else              rdMux = bankRd[pageQ];
  end

  // Read capture, held for the whole strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      rdActive <= 1'b0;
      statRead <= 1'b0;
    end else if (strobe.rdLatch) begin
      rdData   <= rdMux;
      rdActive <= 1'b1;
      statRead <= hitStat;
    end else if (strobe.rdDone) begin
      rdActive <= 1'b0;
      statRead <= 1'b0;
    end
  end
endmodule

// File: rtl/parbus_regif.sv
module parbus_regif
  import hbus_pkg::*;
#(
  parameter int NUM_PAGES   = 2,
  parameter int INT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 intelMode,
  input  logic                 csN,
  input  logic                 rdDsN,
  input  logic                 wrRwN,
  input  logic [HB_ADDR_W-1:0] addr,
  input  logic [HB_DATA_W-1:0] dataIn,
  output logic [HB_DATA_W-1:0] dataOut,
  output logic                 dataOe,
  input  logic [INT_W-1:0]     intSrc,
  output logic                 irqN
);
  hbStrobe_t        strobe;
  logic             rdActive;
  logic [INT_W-1:0] pendQ, enQ;

  hbus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .intelMode(intelMode), .csN(csN),
    .rdDsN(rdDsN), .wrRwN(wrRwN), .addr(addr), .dataIn(dataIn),
    .strobe(strobe)
  );

  hbus_datapath #(.NUM_PAGES(NUM_PAGES), .INT_W(INT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intSrc(intSrc),
    .rdData(dataOut), .rdActive(rdActive), .pendQ(pendQ), .enQ(enQ)
  );

  // Chip select releases the bus at once, with no clock delay
  assign dataOe = rdActive && !csN;
  // Open-drain request: low while any enabled bit is pending
  assign irqN   = !(|(pendQ & enQ));
endmodule

// File: rtl/hbus_checker.sv
module hbus_checker
  import hbus_pkg::*;
#(
  parameter int INT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             dataOe,
  input hbStrobe_t        strobe,
  input logic [INT_W-1:0] pendQ,
  input logic [INT_W-1:0] intSrc
);
  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !csN);  // R4

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCommit |=> !strobe.wrCommit);  // R6

  AST_RD_WR_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdLatch && strobe.wrCommit));  // R2

  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdDone |=> ((pendQ & $past(pendQ)) == $past(pendQ)));  // R8

  AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (|intSrc) |=> ((pendQ & $past(intSrc)) == $past(intSrc)));  // R7
endmodule

bind parbus_regif hbus_checker #(.INT_W(INT_W)) u_hbus_checker (
  .clk(clk), .rstN(rstN), .csN(csN), .dataOe(dataOe),
  .strobe(strobe), .pendQ(pendQ), .intSrc(intSrc)
);

// File: tb/test_parbus_regif.sv
module test_parbus_regif;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       intelMode = 1'b1;
  logic       csN = 1'b1;
  logic       rdDsN = 1'b1;
  logic       wrRwN = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOe;
  logic [7:0] intSrc = '0;
  logic       irqN;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  parbus_regif i_parbus_regif (
    .clk(clk), .rstN(rstN), .intelMode(intelMode), .csN(csN),
    .rdDsN(rdDsN), .wrRwN(wrRwN), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .intSrc(intSrc), .irqN(irqN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input bit intel, input logic [4:0] a,
                          input logic [7:0] d);
    @(negedge clk);
    intelMode = intel; addr = a; dataIn = d; csN = 1'b0;
    if (intel) wrRwN = 1'b0;
    else begin wrRwN = 1'b0; @(negedge clk); rdDsN = 1'b0; end
    repeat (4) @(negedge clk);
    if (intel) wrRwN = 1'b1; else rdDsN = 1'b1;
    repeat (3) @(negedge clk);
    wrRwN = 1'b1; csN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic busRead(input bit intel, input logic [4:0] a,
                         output logic [7:0] d, output logic oe);
    @(negedge clk);
    intelMode = intel; addr = a; csN = 1'b0; wrRwN = 1'b1;
    if (!intel) @(negedge clk);
    rdDsN = 1'b0;
    repeat (5) @(negedge clk);
    d = dataOut; oe = dataOe;
    rdDsN = 1'b1;
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d; logic oe;
    chk("R1 dataOe after reset", dataOe, 0);
    chk("R1 irqN after reset", irqN, 1);
    busRead(1, 5'h1F, d, oe); chk("R1 page after reset", d, 8'h00);
    busRead(1, 5'h05, d, oe); chk("R1 storage after reset", d, 8'h00);
  endtask

  task automatic testIntel();
    logic [7:0] d; logic oe;
    busWrite(1, 5'h05, 8'hA5);
    busRead(1, 5'h05, d, oe);
    chk("R2 intel readback", d, 8'hA5);
    chk("R10 dataOe during read", oe, 1);
    chk("R10 dataOe after read", dataOe, 0);
  endtask

  task automatic testMoto();
    logic [7:0] d; logic oe;
    busWrite(0, 5'h06, 8'h3C);
    busRead(0, 5'h06, d, oe); chk("R3 motorola readback", d, 8'h3C);
    busRead(0, 5'h05, d, oe); chk("R3 cross-mode readback", d, 8'hA5);
  endtask

  task automatic testCsHigh();
    logic [7:0] d; logic oe;
    logic sawOe = 1'b0;
    @(negedge clk);
    intelMode = 1'b1; addr = 5'h05; dataIn = 8'hFF; csN = 1'b1;
    wrRwN = 1'b0;
    repeat (4) begin @(negedge clk); if (dataOe) sawOe = 1'b1; end
    wrRwN = 1'b1; rdDsN = 1'b0;
    repeat (5) begin @(negedge clk); if (dataOe) sawOe = 1'b1; end
    rdDsN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 no dataOe with csN high", sawOe, 0);
    busRead(1, 5'h05, d, oe); chk("R4 no write with csN high", d, 8'hA5);
  endtask

  task automatic testPaging();
    logic [7:0] d; logic oe;
    busWrite(1, 5'h1F, 8'hFD);
    busRead(1, 5'h1F, d, oe); chk("R5 page reads bit0 only", d, 8'h01);
    busWrite(1, 5'h05, 8'h77);
    busRead(0, 5'h05, d, oe); chk("R5 page1 value", d, 8'h77);
    busWrite(0, 5'h1F, 8'h00);
    busRead(1, 5'h05, d, oe); chk("R5 page0 value kept", d, 8'hA5);
  endtask

  task automatic testLastData();
    logic [7:0] d; logic oe;
    @(negedge clk);
    intelMode = 1'b1; addr = 5'h07; dataIn = 8'h55; csN = 1'b0;
    wrRwN = 1'b0;
    repeat (3) @(negedge clk);
    dataIn = 8'h66;
    repeat (3) @(negedge clk);
    wrRwN = 1'b1;
    repeat (3) @(negedge clk);
    csN = 1'b1;
    repeat (2) @(negedge clk);
    busRead(1, 5'h07, d, oe); chk("R6 last data committed", d, 8'h66);
  endtask

  task automatic testIrq();
    logic [7:0] d; logic oe;
    @(negedge clk); intSrc = 8'h04;
    @(negedge clk); intSrc = 8'h00;
    @(negedge clk);
    chk("R9 disabled source no irq", irqN, 1);
    busWrite(1, 5'h01, 8'h04);
    chk("R7 irq low with csN high", irqN, 0);
    chk("R7 csN idle during irq", csN, 1);
    busRead(1, 5'h00, d, oe); chk("R8 status read", d, 8'h04);
    chk("R8 irq released after read", irqN, 1);
    busRead(1, 5'h00, d, oe); chk("R8 status cleared", d, 8'h00);
    busRead(1, 5'h01, d, oe); chk("R9 enable readback", d, 8'h04);
    @(negedge clk); intSrc = 8'h10;
    @(negedge clk); intSrc = 8'h00;
    @(negedge clk);
    chk("R7 irq timing two cycles, disabled bit", irqN, 1);
    busWrite(1, 5'h00, 8'hFF);
    busRead(1, 5'h00, d, oe); chk("R9 status write ignored", d, 8'h10);
  endtask

  task automatic testCsDrop();
    @(negedge clk);
    intelMode = 1'b1; addr = 5'h05; csN = 1'b0; rdDsN = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 dataOe high in read", dataOe, 1);
    csN = 1'b1;
    #1;
    chk("R10 dataOe drops with csN", dataOe, 0);
    rdDsN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testIntel();
    testMoto();
    testCsHigh();
    testPaging();
    testLastData();
    testIrq();
    testCsDrop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule